// File: doc/BRIEF.md
# Control-Flow Signature Monitor

This block watches a program's path through its basic blocks and reports when that path departs from a legal one. It keeps one run-time signature register. Each time execution enters a basic block, the host raises a strobe. With the strobe it supplies two values fixed for that block before execution: a difference constant and the block's assigned signature. The monitor XORs the register with the difference constant and compares the result with the assigned signature. The register takes the XOR result whether or not the two agree.

The signature is never looked up at run time. It is rebuilt step by step, so it reaches the assigned value only when the blocks were entered in a legal order. On a mismatch the monitor sets an error flag that stays set until the host clears it. On the first such mismatch it also issues a one-cycle restart request. Before the program starts, a load input writes the entry block's signature into the register.

Top module: `cf_sig_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `cur_sig` equals the parameter `INIT_SIG` (default 0), and `err_flag` and `restart` are 0.
- R2: When `load_en` is high at a rising clock edge, `cur_sig` equals `load_sig` from the next cycle.
- R3: When `enter` is high and `load_en` is low at an edge, `cur_sig` becomes the previous `cur_sig` XOR `diff_const`. This holds whether or not the comparison succeeds.
- R4: A block entry whose XOR result equals `block_sig` leaves `err_flag` unchanged and produces no `restart`.
- R5: A block entry whose XOR result differs from `block_sig` sets `err_flag` from the next cycle. The flag then stays at 1 until it is cleared.
- R6: A mismatch that occurs while `err_flag` is 0 produces `restart` high for exactly one cycle, in the same cycle that `err_flag` first reads 1. A mismatch that occurs while `err_flag` is already 1 produces no `restart`.
- R7: `err_clr` high at an edge clears `err_flag` in the next cycle. If a mismatch occurs in the same cycle as `err_clr`, the mismatch wins and `err_flag` stays 1.
- R8: When `load_en` and `enter` are high together, the load wins. No comparison is made, `cur_sig` takes `load_sig`, and there is neither a `restart` nor a change to `err_flag`.
- R9: With `enter` and `load_en` both low, `cur_sig` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Writes `load_sig` into the signature register |
| load_sig | input | SIG_W | Initial signature (the entry block's signature) |
| enter | input | 1 | Basic-block entry strobe |
| diff_const | input | SIG_W | Difference constant of the block being entered |
| block_sig | input | SIG_W | Assigned signature of the block being entered |
| err_clr | input | 1 | Clears the error flag |
| err_flag | output | 1 | Sticky control-flow error |
| restart | output | 1 | One-cycle restart request on the first mismatch |
| cur_sig | output | SIG_W | Current run-time signature |

## Verification
The properties assume that every input is stable and known at each rising edge while reset is released. They also assume that reset is applied with `enter`, `load_en` and `err_clr` low, because the first checks after reset compare against the input values sampled during reset. The bench changes inputs only on falling edges and holds all strobes low around each reset. It includes cycles in which the strobes overlap: a load together with an entry, and a clear together with a mismatch.

// File: rtl/cf_sig_monitor.sv
module cf_sig_monitor #(
  parameter int unsigned     SIG_W    = 8,
  parameter logic [SIG_W-1:0] INIT_SIG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [SIG_W-1:0] load_sig,
  input  logic             enter,
  input  logic [SIG_W-1:0] diff_const,
  input  logic [SIG_W-1:0] block_sig,
  input  logic             err_clr,
  output logic             err_flag,
  output logic             restart,
  output logic [SIG_W-1:0] cur_sig
);

  logic [SIG_W-1:0] sig_q;
  logic             err_q;
  logic             rst_req_q;
  logic [SIG_W-1:0] next_sig;
  logic             check_en;
  logic             miss;

  assign next_sig = sig_q ^ diff_const;
  assign check_en = enter & ~load_en;
  assign miss     = check_en & (next_sig != block_sig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q     <= INIT_SIG;
      err_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (load_en)
        sig_q <= load_sig;
      else if (enter)
        sig_q <= next_sig;

      if (miss)
        err_q <= 1'b1;
      else if (err_clr)
        err_q <= 1'b0;

      rst_req_q <= miss & ~err_q;
    end
  end

  assign cur_sig  = sig_q;
  assign err_flag = err_q;
  assign restart  = rst_req_q;

endmodule

// File: rtl/cf_sig_monitor_chk.sv
module cf_sig_monitor_chk #(
  parameter int unsigned SIG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic [SIG_W-1:0] load_sig,
  input logic             enter,
  input logic [SIG_W-1:0] diff_const,
  input logic [SIG_W-1:0] block_sig,
  input logic             err_clr,
  input logic             err_flag,
  input logic             restart,
  input logic [SIG_W-1:0] cur_sig
);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cur_sig == $past(load_sig));

  // R3
  xor_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && !load_en) |=> cur_sig == ($past(cur_sig) ^ $past(diff_const)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter && !load_en) |=> $stable(cur_sig));

  // R5
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  // R6
  restart_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> err_flag);

  // R6
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  // R6
  restart_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> !restart);

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (!restart && err_flag == $past(err_flag && !err_clr)));

  // R4
  match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && !load_en && ((cur_sig ^ diff_const) == block_sig)) |=> !restart);

endmodule

bind cf_sig_monitor cf_sig_monitor_chk #(.SIG_W(SIG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sig(load_sig),
  .enter(enter), .diff_const(diff_const), .block_sig(block_sig),
  .err_clr(err_clr), .err_flag(err_flag), .restart(restart),
  .cur_sig(cur_sig)
);

// File: tb/cf_sig_monitor_tb.sv
module cf_sig_monitor_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic [7:0] load_sig = '0;
  logic       enter = 1'b0;
  logic [7:0] diff_const = '0;
  logic [7:0] block_sig = '0;
  logic       err_clr = 1'b0;
  logic       err_flag;
  logic       restart;
  logic [7:0] cur_sig;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cf_sig_monitor #(.SIG_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sig(load_sig),
    .enter(enter), .diff_const(diff_const), .block_sig(block_sig),
    .err_clr(err_clr), .err_flag(err_flag), .restart(restart),
    .cur_sig(cur_sig)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic [7:0] lv, input logic en,
                      input logic [7:0] dc, input logic [7:0] bs, input logic clr);
    @(negedge clk);
    load_en = ld; load_sig = lv; enter = en;
    diff_const = dc; block_sig = bs; err_clr = clr;
    @(negedge clk);
    load_en = 1'b0; enter = 1'b0; err_clr = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 sig in reset", cur_sig, 8'h00);
    chk("R1 err in reset", err_flag, 0);
    chk("R1 restart in reset", restart, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sig after reset", cur_sig, 8'h00);
    chk("R1 err after reset", err_flag, 0);
  endtask

  task automatic t_load;
    step(1'b1, 8'h8b, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R2 loaded sig", cur_sig, 8'h8b);
  endtask

  task automatic t_match;
    step(1'b0, 8'h00, 1'b1, 8'h3c, 8'hb7, 1'b0);
    chk("R3 xor update", cur_sig, 8'hb7);
    chk("R4 no err on match", err_flag, 0);
    chk("R4 no restart on match", restart, 0);
  endtask

  task automatic t_hold;
    repeat (3) @(negedge clk);
    chk("R9 idle hold", cur_sig, 8'hb7);
  endtask

  task automatic t_mismatch;
    step(1'b0, 8'h00, 1'b1, 8'h11, 8'h00, 1'b0);
    chk("R3 update on mismatch", cur_sig, 8'ha6);
    chk("R5 err set", err_flag, 1);
    chk("R6 restart pulse", restart, 1);
    @(negedge clk);
    chk("R6 restart one cycle", restart, 0);
    chk("R5 err sticky", err_flag, 1);
  endtask

  task automatic t_second_miss;
    step(1'b0, 8'h00, 1'b1, 8'h01, 8'h00, 1'b0);
    chk("R3 second update", cur_sig, 8'ha7);
    chk("R6 no restart when flagged", restart, 0);
    chk("R5 still set", err_flag, 1);
  endtask

  task automatic t_clear;
    step(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
    chk("R7 clear", err_flag, 0);
    step(1'b0, 8'h00, 1'b1, 8'h07, 8'h00, 1'b1);
    chk("R7 mismatch beats clear", err_flag, 1);
    chk("R6 restart after clear", restart, 1);
    chk("R3 sig", cur_sig, 8'ha0);
    step(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
    chk("R7 clear again", err_flag, 0);
  endtask

  task automatic t_priority;
    step(1'b1, 8'h20, 1'b1, 8'hff, 8'h00, 1'b0);
    chk("R8 load wins sig", cur_sig, 8'h20);
    chk("R8 no err", err_flag, 0);
    chk("R8 no restart", restart, 0);
    step(1'b0, 8'h00, 1'b1, 8'h05, 8'h25, 1'b0);
    chk("R4 legal chain after load", cur_sig, 8'h25);
    chk("R4 chain no err", err_flag, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_load();
    t_match();
    t_hold();
    t_mismatch();
    t_second_miss();
    t_clear();
    t_priority();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule